// File: doc/BRIEF.md
# Dual Event and Timestamp Timer

This block is a bus-attached peripheral with two independent counters that share one clock and one tick-enable input. The event counter is a 56-bit down-counter. Software commits a reload value and starts it. When it expires it raises a pending flag, and after expiry it either stops (one-shot) or reloads and runs again (repeat). The timestamp counter is a free-running 64-bit up-counter that software reads as two live 32-bit words.

Software reaches the block through a single-cycle 32-bit register port. A write is taken on the clock edge where `req_i` and `we_i` are both high. Read data is combinational from `addr_i`. The reload value is split across two registers. The low 32 bits are written first, then the upper 24 bits together with the control flags, and a load strobe in that second write commits all 56 bits at once. The interrupt mask is changed through separate set and clear registers, and the pending flag is acknowledged through a third register. The level output `irq_o` is the pending flag gated by the mask. Both counters advance only on clock edges where `tick_i` is high, so a divided system clock can supply the slow count rate.

Top module: `tmr_top`

## Requirements
- R1: After reset these all read 0 and `irq_o` is low: the load-low word at 0x000, the control word at 0x004, the interrupt mask and the pending flag. The timestamp counter starts at parameter `STAMP_INIT`, which defaults to 0.
- R2: A write to 0x004 with bit 30 set copies {wdata[23:0], load-low word} into the event counter and keeps that value as the reload value. Writing 0x000 after the commit does not change the running count, and 0x000 reads back the last value written to it.
- R3: The event counter decrements only on edges with `tick_i` high and the timer enabled. After a commit of N, it expires on the N-th such edge, and a commit of 0 expires on the first.
- R4: In one-shot mode (control bit 28 clear), expiry stops the counter and clears the enable bit (control bit 24). No further expiry follows.
- R5: In repeat mode (control bit 28 set), expiry reloads the committed value and the enable bit stays set, so expiries recur every N enabled ticks.
- R6: A write of 0 to 0x004 stops the event counter, and no expiry follows it.
- R7: Expiry sets the pending flag whatever the mask is. `irq_o` equals pending AND mask. Bit 0 written as 1 to 0x02C sets the mask, and bit 0 written as 1 to 0x030 clears it.
- R8: Bit 0 written as 1 to 0x034 clears the pending flag. If an expiry happens in the same cycle, the flag stays set.
- R9: The control word reads back with bits [23:0] as the upper reload field, bit 24 as enable and bit 28 as repeat. All other bits, including the load strobe bit 30, read as 0. Addresses 0x02C, 0x030, 0x034 and any unmapped address read 0.
- R10: The timestamp counter increments by 1 on each edge with `tick_i` high. Its bits [31:0] read at 0x024 and bits [63:32] at 0x028. Both reads are live, so the high word is not captured when the low word is read, and a carry out of the low word shows up in the high word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable for both counters |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Level interrupt: pending AND mask |

## Verification
The bench targets the expiry edge exactly. If the countdown were off by one, `irq_o` would rise a cycle early or late. If the write of a new low word after a commit leaked into the counter, the expiry would move. It also drives an acknowledge into the very cycle of a repeat-mode expiry. A design that let the clear win would drop that interrupt. The bench starts the timestamp counter just below a low-word carry so that a missed carry shows up as a wrong high word. It also checks that a masked expiry still leaves a pending flag, which a wrong design would lose, and that the one-shot enable bit and the load strobe read back as zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_LOAD_LO = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CTRL    = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_STAMP_L = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_STAMP_H = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_MSK_SET = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_MSK_CLR = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_ACK     = 8'h34;

  localparam int BIT_EN  = 24;
  localparam int BIT_RPT = 28;
  localparam int BIT_LD  = 30;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_LOAD, SEL_CTRL, SEL_SLO, SEL_SHI, SEL_MSET, SEL_MCLR, SEL_ACK
  } sel_e;
endpackage

// File: rtl/tmr_event.sv
module tmr_event
  import tmr_pkg::*;
#(
  parameter int EVT_W = 56,
  localparam int HI_W = EVT_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ctrl_wr_i,
  input  logic              ld_i,
  input  logic              en_bit_i,
  input  logic              rpt_bit_i,
  input  logic [HI_W-1:0]   hi_i,
  input  logic [DATA_W-1:0] load_lo_i,
  output logic              en_o,
  output logic              rpt_o,
  output logic [HI_W-1:0]   hi_o,
  output logic              expire_o
);
  logic [EVT_W-1:0] cnt_q, reload_q;
  logic             en_q, rpt_q;
  logic [HI_W-1:0]  hi_q;

  assign expire_o = en_q && tick_i && (cnt_q <= EVT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      reload_q <= '0;
      en_q     <= 1'b0;
      rpt_q    <= 1'b0;
      hi_q     <= '0;
    end else begin
      if (expire_o) begin
        if (rpt_q) cnt_q <= reload_q;
        else begin
          cnt_q <= '0;
          en_q  <= 1'b0;
        end
      end else if (en_q && tick_i) begin
        cnt_q <= cnt_q - EVT_W'(1);
      end
      // a control write overrides the count step
      if (ctrl_wr_i) begin
        en_q  <= en_bit_i;
        rpt_q <= rpt_bit_i;
        hi_q  <= hi_i;
        if (ld_i) begin
          cnt_q    <= {hi_i, load_lo_i};
          reload_q <= {hi_i, load_lo_i};
        end
      end
    end
  end

  assign en_o  = en_q;
  assign rpt_o = rpt_q;
  assign hi_o  = hi_q;

  AST_LOAD_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && ld_i |=> cnt_q == $past({hi_i, load_lo_i})); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !ctrl_wr_i |=> $stable(cnt_q)); // R3
  AST_ONESHOT_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o && !rpt_q && !ctrl_wr_i |=> !en_q); // R4
  AST_REPEAT_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o && rpt_q && !ctrl_wr_i |=> en_q && cnt_q == reload_q); // R5
  AST_STOP_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && !en_bit_i |=> !expire_o); // R6
endmodule

// File: rtl/tmr_stamp.sv
module tmr_stamp #(
  parameter int                 STAMP_W    = 64,
  parameter logic [STAMP_W-1:0] STAMP_INIT = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  output logic [STAMP_W-1:0] cnt_o
);
  logic [STAMP_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= STAMP_INIT;
    else if (tick_i) cnt_q <= cnt_q + STAMP_W'(1);
  end

  assign cnt_o = cnt_q;

  AST_STAMP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_q == $past(cnt_q) + STAMP_W'(1)); // R10
  AST_STAMP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int HI_W    = 24,
  parameter int STAMP_W = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               en_i,
  input  logic               rpt_i,
  input  logic [HI_W-1:0]    hi_i,
  input  logic [STAMP_W-1:0] stamp_i,
  input  logic               expire_i,
  output logic               ctrl_wr_o,
  output logic [DATA_W-1:0]  load_lo_o,
  output logic               irq_o,
  output logic [DATA_W-1:0]  rdata_o
);
  sel_e        sel;
  logic        wr;
  logic        mask_q, pend_q;
  logic [DATA_W-1:0] load_lo_q, ctrl_rd;

  always_comb begin
    unique case (addr_i)
      OFF_LOAD_LO: sel = SEL_LOAD;
      OFF_CTRL:    sel = SEL_CTRL;
      OFF_STAMP_L: sel = SEL_SLO;
      OFF_STAMP_H: sel = SEL_SHI;
      OFF_MSK_SET: sel = SEL_MSET;
      OFF_MSK_CLR: sel = SEL_MCLR;
      OFF_ACK:     sel = SEL_ACK;
      default:     sel = SEL_NONE;
    endcase
  end

  assign wr        = req_i && we_i;
  assign ctrl_wr_o = wr && (sel == SEL_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_lo_q <= '0;
      mask_q    <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      if (wr && sel == SEL_LOAD) load_lo_q <= wdata_i;
      if (wr && sel == SEL_MSET && wdata_i[0]) mask_q <= 1'b1;
      else if (wr && sel == SEL_MCLR && wdata_i[0]) mask_q <= 1'b0;
      if (expire_i) pend_q <= 1'b1;
      else if (wr && sel == SEL_ACK && wdata_i[0]) pend_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_rd              = '0;
    ctrl_rd[HI_W-1:0]    = hi_i;
    ctrl_rd[BIT_EN]      = en_i;
    ctrl_rd[BIT_RPT]     = rpt_i;
  end

  always_comb begin
    unique case (sel)
      SEL_LOAD: rdata_o = load_lo_q;
      SEL_CTRL: rdata_o = ctrl_rd;
      SEL_SLO:  rdata_o = stamp_i[DATA_W-1:0];
      SEL_SHI:  rdata_o = DATA_W'(stamp_i >> DATA_W);
      default:  rdata_o = '0;
    endcase
  end

  assign load_lo_o = load_lo_q;
  assign irq_o     = pend_q && mask_q;

  AST_PEND_ON_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> pend_q); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && sel == SEL_ACK && wdata_i[0] && !expire_i |=> !pend_q); // R8
  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && sel == SEL_MSET && wdata_i[0] |=> mask_q); // R7
  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && sel == SEL_MCLR && wdata_i[0] |=> !irq_o); // R7
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter int                 EVT_W      = 56,
  parameter int                 STAMP_W    = 64,
  parameter logic [STAMP_W-1:0] STAMP_INIT = '0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  localparam int HI_W = EVT_W - DATA_W;

  logic               ctrl_wr, en, rpt, expire;
  logic [HI_W-1:0]    hi;
  logic [DATA_W-1:0]  load_lo;
  logic [STAMP_W-1:0] stamp;

  tmr_regs #(.HI_W(HI_W), .STAMP_W(STAMP_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .en_i(en), .rpt_i(rpt), .hi_i(hi), .stamp_i(stamp), .expire_i(expire),
    .ctrl_wr_o(ctrl_wr), .load_lo_o(load_lo), .irq_o, .rdata_o
  );

  tmr_event #(.EVT_W(EVT_W)) u_event (
    .clk_i, .rst_ni, .tick_i,
    .ctrl_wr_i(ctrl_wr), .ld_i(wdata_i[BIT_LD]),
    .en_bit_i(wdata_i[BIT_EN]), .rpt_bit_i(wdata_i[BIT_RPT]),
    .hi_i(wdata_i[HI_W-1:0]), .load_lo_i(load_lo),
    .en_o(en), .rpt_o(rpt), .hi_o(hi), .expire_o(expire)
  );

  tmr_stamp #(.STAMP_W(STAMP_W), .STAMP_INIT(STAMP_INIT)) u_stamp (
    .clk_i, .rst_ni, .tick_i, .cnt_o(stamp)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(expire) || $past(req_i && we_i)); // R7
endmodule

// File: tb/tmr_top_tb.sv
module tmr_top_tb;
  localparam longint unsigned INIT = 64'h0000_0000_FFFF_FFF0;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;

  int checks = 0, fails = 0, tick_div = 0, ph = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr_top #(.STAMP_INIT(INIT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  longint unsigned m_cnt = 0, m_rel = 0, m_stamp = INIT;
  int unsigned m_lo = 0, m_hi = 0;
  bit m_en = 0, m_rpt = 0, m_pend = 0, m_mask = 0;

  always @(posedge clk) begin
    bit exp;
    if (!rst_n) begin
      m_cnt = 0; m_rel = 0; m_stamp = INIT; m_lo = 0; m_hi = 0;
      m_en = 0; m_rpt = 0; m_pend = 0; m_mask = 0;
    end else begin
      exp = m_en && tick && (m_cnt <= 1);
      if (exp) begin
        if (m_rpt) m_cnt = m_rel;
        else begin m_cnt = 0; m_en = 0; end
      end else if (m_en && tick) m_cnt = m_cnt - 1;
      if (tick) m_stamp = m_stamp + 1;
      if (req && we) begin
        case (addr)
          8'h04: begin
            m_en = wdata[24]; m_rpt = wdata[28]; m_hi = wdata[23:0];
            if (wdata[30]) begin
              m_cnt = {8'h0, wdata[23:0], m_lo};
              m_rel = m_cnt;
            end
          end
          8'h2C: if (wdata[0]) m_mask = 1;
          8'h30: if (wdata[0]) m_mask = 0;
          8'h34: if (wdata[0] && !exp) m_pend = 0;
          default: ;
        endcase
        if (addr == 8'h00) m_lo = wdata;
      end
      if (exp) m_pend = 1;
    end
  end

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h00: return m_lo;
      8'h04: return {3'b0, m_rpt, 3'b0, m_en, m_hi[23:0]};
      8'h24: return m_stamp[31:0];
      8'h28: return m_stamp[63:32];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h00: return "R2";
      8'h04: return "R9";
      8'h24, 8'h28: return "R10";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    check("R7", irq, m_pend && m_mask);
    if (req && !we) check(tag_of(addr), rdata, m_read(addr));
  end

  // tick generator
  initial forever begin
    @(posedge clk); #1;
    if (tick_div == 0) tick = 0;
    else begin ph = (ph + 1) % tick_div; tick = (ph == 0); end
  end

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #2;
    req = 0; we = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    req = 1; we = 0; addr = a;
    #1 check(tag, rdata, exp);
    req = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    wait_n(1);

    // R1: reset state
    check("R1", irq, 0);
    rd(8'h00, 0, "R1"); rd(8'h04, 0, "R1");
    rd(8'h24, 32'hFFFF_FFF0, "R1"); rd(8'h28, 0, "R1");

    // R10: carry from low word into high word
    tick_div = 1;
    wait_n(20);
    tick_div = 0;
    wait_n(2);
    rd(8'h24, 32'h0000_0004, "R10"); rd(8'h28, 32'h1, "R10");
    tick_div = 1;
    wait_n(2);

    // R3/R4: one-shot of 5
    wr(8'h2C, 1);
    wr(8'h00, 5); wr(8'h04, 32'h4100_0000);
    wait_n(4); check("R3", irq, 0);
    wait_n(1); check("R3", irq, 1);
    rd(8'h04, 0, "R4");
    wait_n(10); check("R4", irq, 1);
    wr(8'h34, 1); check("R8", irq, 0);
    wait_n(10); check("R4", irq, 0);

    // R7: masked expiry still pends
    wr(8'h30, 1);
    wr(8'h00, 3); wr(8'h04, 32'h4100_0000);
    wait_n(5); check("R7", irq, 0);
    wr(8'h2C, 1); check("R7", irq, 1);
    wr(8'h34, 1);

    // R5/R8/R6: repeat of 4
    wr(8'h00, 4); wr(8'h04, 32'h5100_0000);
    wait_n(4); check("R5", irq, 1);
    wr(8'h34, 1); check("R8", irq, 0);
    wait_n(2); check("R5", irq, 0);
    wait_n(1); check("R5", irq, 1);
    rd(8'h04, 32'h1100_0000, "R9");
    wait_n(3);
    wr(8'h34, 1); check("R8", irq, 1);
    wr(8'h04, 0); wr(8'h34, 1);
    wait_n(20); check("R6", irq, 0);

    // R9/R2: readback and commit isolation
    wr(8'h04, 32'h40AB_CDEF); rd(8'h04, 32'h00AB_CDEF, "R9");
    rd(8'h2C, 0, "R9"); rd(8'h30, 0, "R9"); rd(8'h34, 0, "R9"); rd(8'h40, 0, "R9");
    wr(8'h00, 6); wr(8'h04, 32'h4100_0000); wr(8'h00, 100);
    wait_n(4); check("R2", irq, 0);
    wait_n(1); check("R2", irq, 1);
    rd(8'h00, 100, "R2");
    wr(8'h34, 1);

    // R3: no count without ticks
    tick_div = 0;
    wr(8'h00, 2); wr(8'h04, 32'h4100_0000);
    wait_n(10); check("R3", irq, 0);
    tick_div = 1;
    wait_n(6); check("R3", irq, 1);
    wr(8'h34, 1);

    // R3: divided tick
    tick_div = 3;
    wr(8'h00, 2); wr(8'h04, 32'h4100_0000);
    wait_n(12); check("R3", irq, 1);
    rd(8'h24, m_read(8'h24), "R10"); rd(8'h28, m_read(8'h28), "R10");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule